// File: doc/BRIEF.md
# Car Park Occupancy Counter

This block keeps the number of vehicles inside a single-digit car park. Event pulses that last one cycle, raised when a vehicle completes its passage inwards or outwards, move a four-bit binary count up or down. The count is held between 0 and 9. It drives one common-cathode seven-segment digit. Three lamps report the state: red when the park is full, green when there is space, and yellow while a beam sensor is blocked. The full flag also goes out on its own port, so that a gate controller can refuse entry.

An operator push-button clears the count to zero. The button is asynchronous and bounces, so the block first passes it through a two-stage synchronizer and then a debounce counter. A press takes effect only after the synchronized level has held steady for `DEB_LEN` consecutive cycles.

Top module: `park_occupancy`

## Requirements
- R1: After reset the count is 0, the red lamp and the full flag are low, and the green lamp is high.
- R2: An entry pulse on its own, with the count below 9, raises the count by one on the next clock edge.
- R3: An exit pulse on its own, with the count above 0, lowers the count by one on the next clock edge.
- R4: An entry pulse while the count is 9 leaves the count at 9. The count never exceeds 9.
- R5: An exit pulse while the count is 0 leaves the count at 0.
- R6: When entry and exit pulses arrive in the same cycle, the count does not change.
- R7: The full flag is count bit 3 AND count bit 0, which is high only at 9. The red lamp equals the full flag and the green lamp is its inverse.
- R8: The yellow lamp follows the sensor-busy input combinationally.
- R9: The segment bus is {g,f,e,d,c,b,a}, with bit 0 as segment a. It is active high and shows digits 0..9 with the codes 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R10: When the clear button is held steady for at least `DEB_LEN` cycles after synchronization, the count becomes 0. It stays at 0 for as long as the button is held, and entry pulses are ignored during that time.
- R11: A button press shorter than `DEB_LEN` cycles has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_pulse | input | 1 | One-cycle pulse when a vehicle has come in |
| exit_pulse | input | 1 | One-cycle pulse when a vehicle has gone out |
| clear_btn | input | 1 | Raw clear push-button, high while pressed |
| sensor_busy | input | 1 | High while either beam is blocked |
| count | output | 4 | Binary vehicle count, 0..9 |
| seg | output | 7 | Segments {g,f,e,d,c,b,a}, active high |
| lamp_red | output | 1 | No space left |
| lamp_green | output | 1 | Space available |
| lamp_yellow | output | 1 | Vehicle in transit |
| full | output | 1 | Full flag for the gate controller |

## Verification
The assertions check on every cycle that the count stays within 0..9. They also check that a lone entry or exit moves the count by exactly one, that simultaneous pulses hold it, that the full flag matches a count of nine, and that a debounced press forces zero. Only the bench scenarios can show the actual digit patterns, the behaviour at both ends of the range under long pulse sequences, and the timing of the debounce filter. That includes a glitch being rejected and a long press clearing the count.

// File: rtl/park_occupancy.sv
module park_occupancy #(
  parameter int DEB_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry_pulse,
  input  logic       exit_pulse,
  input  logic       clear_btn,
  input  logic       sensor_busy,
  output logic [3:0] count,
  output logic [6:0] seg,
  output logic       lamp_red,
  output logic       lamp_green,
  output logic       lamp_yellow,
  output logic       full
);
  localparam int DW = (DEB_LEN > 2) ? $clog2(DEB_LEN) : 1;
  localparam logic [3:0] TOP = 4'd9;
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_LEN - 1);

  logic [1:0]    btn_sync;
  logic          btn_held;
  logic [DW-1:0] deb_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_sync <= '0;
      btn_held <= 1'b0;
      deb_cnt  <= '0;
    end else begin
      btn_sync <= {btn_sync[0], clear_btn};
      if (btn_sync[1] == btn_held) begin
        deb_cnt <= '0;
      end else if (deb_cnt == DEB_LAST) begin
        btn_held <= btn_sync[1];
        deb_cnt  <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end
  end

  logic do_inc, do_dec;
  assign do_inc = entry_pulse & ~exit_pulse & (count != TOP);
  assign do_dec = exit_pulse & ~entry_pulse & (count != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= 4'd0;
    else if (btn_held) count <= 4'd0;
    else if (do_inc)   count <= count + 4'd1;
    else if (do_dec)   count <= count - 4'd1;
  end

  always_comb begin
    case (count)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end

  assign full        = count[3] & count[0];
  assign lamp_red    = full;
  assign lamp_green  = ~full;
  assign lamp_yellow = sensor_busy;

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP);

  // R2
  entry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && !exit_pulse && !btn_held && count < TOP) |=> count == $past(count) + 4'd1);

  // R3
  exit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pulse && !entry_pulse && !btn_held && count > 4'd0) |=> count == $past(count) - 4'd1);

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_pulse && exit_pulse && !btn_held) |=> $stable(count));

  // R7
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full == (count == 4'd9));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_held |=> count == 4'd0);
endmodule

// File: tb/park_occupancy_bench.sv
module park_occupancy_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_pulse = 1'b0, exit_pulse = 1'b0, clear_btn = 1'b0, sensor_busy = 1'b0;
  logic [3:0] count;
  logic [6:0] seg;
  logic lamp_red, lamp_green, lamp_yellow, full;

  int checks = 0;
  int fails = 0;
  int expc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  park_occupancy #(.DEB_LEN(DEB)) u_park_occupancy (
    .clk(clk), .rst_n(rst_n), .entry_pulse(entry_pulse), .exit_pulse(exit_pulse),
    .clear_btn(clear_btn), .sensor_busy(sensor_busy), .count(count), .seg(seg),
    .lamp_red(lamp_red), .lamp_green(lamp_green), .lamp_yellow(lamp_yellow), .full(full));

  function automatic logic [6:0] digit(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " count"}, count, expc);
    chk("R9 seg", seg, digit(expc));
    chk("R7 full", full, expc == 9);
    chk("R7 red", lamp_red, expc == 9);
    chk("R7 green", lamp_green, expc != 9);
  endtask

  task automatic pulse(bit e, bit x);
    entry_pulse = e; exit_pulse = x;
    @(negedge clk);
    entry_pulse = 1'b0; exit_pulse = 1'b0;
    if (e && !x && expc < 9) expc++;
    else if (x && !e && expc > 0) expc--;
    if (e && x) check_all("R6");
    else if (e) check_all(expc == 9 ? "R4" : "R2");
    else if (x) check_all(expc == 0 ? "R5" : "R3");
    else check_all("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    for (int i = 0; i < 12; i++) pulse(1'b1, 1'b0);   // R2 R4
    for (int i = 0; i < 12; i++) pulse(1'b0, 1'b1);   // R3 R5
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);                                // R6

    for (int i = 0; i < 2; i++) begin                 // R8
      sensor_busy = (i == 0); #1;
      chk("R8 yellow", lamp_yellow, i == 0);
    end
    sensor_busy = 1'b0;

    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr * 1103515245 + 12345;
      pulse(lfsr[16], lfsr[20]);
    end

    while (expc < 9) pulse(1'b1, 1'b0);
    clear_btn = 1'b1;                                 // R11 short glitch
    repeat (3) @(negedge clk);
    clear_btn = 1'b0;
    repeat (DEB + 6) @(negedge clk);
    check_all("R11");

    clear_btn = 1'b1;                                 // R10 long press
    repeat (DEB + 4) @(negedge clk);
    expc = 0;
    check_all("R10");
    entry_pulse = 1'b1;
    @(negedge clk);
    entry_pulse = 1'b0;
    check_all("R10 held");
    clear_btn = 1'b0;
    repeat (DEB + 4) @(negedge clk);
    pulse(1'b1, 1'b0);
    check_all("R10 release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule